// File: doc/BRIEF.md
# Armed Gate Counter Core

This block is the measuring core of a frequency and period counter. It picks which signal is counted and which signal times the gate, according to the measurement mode. In frequency mode one of two input channels is counted, and the gate is timed by a divided timebase. In period mode a 1 MHz reference is counted, and the gate is timed by channel A.

A one-cycle arm command primes the gate. The next rising edge of the gating signal opens the gate and the edge after that closes it, so the gate stays open for exactly one gating period. A registered done flag then reports the finished measurement.

Counted edges go into a chain of BCD decades. The carry out of the top decade feeds a binary extension made of a low counter and a high counter. All inputs are sampled in one fast system clock. Rising edges of the counted and gating signals are found by comparing each sample with the one taken a clock earlier. A clear command returns the gate and the whole count to zero.

Top module: `gate_counter_core`

## Requirements
- R1: While `rst_n` is low, and in the cycle after a cycle that samples `clearCmd` high, `done` is 0, every digit of `bcdDigits` is 0, `binExt` is 0, and the gate is closed and unarmed. A gating edge that comes later without a new arm counts nothing.
- R2: With `modePeriod` = 0, the counted signal is `chanA` when `chanSel` = 0 and `chanB` when `chanSel` = 1. The gating signal is `gateTb`.
- R3: With `modePeriod` = 1, the counted signal is `periodRef` and the gating signal is `chanA`.
- R4: An arm command that is accepted primes the gate. The first gating rise sampled after that opens it. A counted rise adds one to the count only when it is sampled in a cycle in which the gate was already open before that clock edge. The count keeps its value while the gate is closed.
- R5: The gating rise sampled while the gate is open closes it. In that same edge `done` becomes 1. `done` is 1 only while the gate is neither armed nor open.
- R6: An arm command is accepted only while the gate is neither armed nor open. Accepting it clears `done` in the next cycle. An arm command given while the gate is armed or open has no effect.
- R7: Digit 0 is `bcdDigits[3:0]`, digit i is `bcdDigits[4i+3:4i]`, and each digit is a BCD value from 0 to 9. On a counted edge, digit 0 goes from 9 to 0 and produces a carry.
- R8: Each higher digit advances by one, or wraps from 9 to 0, exactly when the digit below it wraps from 9 to 0.
- R9: A carry out of the top digit adds one to the low binary counter (`binExt[LO_W-1:0]`). When that counter wraps from all ones to zero, the high counter (`binExt[EXT_W-1:LO_W]`) adds one. The whole count wraps to zero after 10^NUM_DECADES × 2^(LO_W+HI_W) counted edges.
- R10: A gating rise that arrives while the gate is not armed changes neither the count nor `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| chanA | input | 1 | Channel A input; counted in frequency mode, gating in period mode |
| chanB | input | 1 | Channel B input (already prescaled) |
| gateTb | input | 1 | Divided timebase gating signal |
| periodRef | input | 1 | 1 MHz period reference |
| modePeriod | input | 1 | 0 = frequency mode, 1 = period mode |
| chanSel | input | 1 | Frequency mode channel: 0 = A, 1 = B |
| armCmd | input | 1 | One-cycle arm request |
| clearCmd | input | 1 | Synchronous clear of the gate and the count |
| done | output | 1 | Measurement finished |
| bcdDigits | output | 4*NUM_DECADES | BCD decades, least significant digit in the low bits |
| binExt | output | LO_W+HI_W | Binary extension above the decades |

## Verification
The assertions assume that the selected gating and counted signals are synchronous to `clk`. They also assume that `clearCmd` alone explains a gate that closes with no `done`. The stimulus therefore changes every input only on the falling clock edge. It keeps all inputs low during reset and changes the mode or the channel only while the gate is idle. This keeps the edge detectors from seeing a mode change as a counted edge while the gate is open. The bench runs with two decades, a 4-bit low counter and a 2-bit high counter, so that full wrap of the count is reached in a short run.

// File: rtl/gcc_pkg.sv
package gcc_pkg;

  // strobes sent from the gate control to the count datapath
  typedef struct packed {
    logic clr;   // zero every counter stage
    logic inc;   // one counted edge while the gate is open
  } dpStrobe_t;

  typedef enum logic {
    MEAS_FREQ   = 1'b0,
    MEAS_PERIOD = 1'b1
  } measMode_e;

  localparam int unsigned DIGIT_W   = 4;
  localparam logic [3:0]  DIGIT_MAX = 4'd9;

endpackage

// File: rtl/gcc_decade.sv
module gcc_decade
  import gcc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               inc,
  output logic [DIGIT_W-1:0] digit,
  output logic               carryOut
);

  logic atMax;

  assign atMax    = (digit == DIGIT_MAX);
  assign carryOut = inc & atMax;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      digit <= '0;
    end else if (clr) begin
      digit <= '0;
    end else if (inc) begin
      digit <= atMax ? '0 : digit + 4'd1;
    end
  end

endmodule

// File: rtl/gcc_binseg.sv
module gcc_binseg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] value,
  output logic         carryOut
);

  assign carryOut = inc & (&value);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value <= '0;
    end else if (clr) begin
      value <= '0;
    end else if (inc) begin
      value <= value + {{(W-1){1'b0}}, 1'b1};
    end
  end

endmodule

// File: rtl/gcc_ctrl.sv
module gcc_ctrl
  import gcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chanA,
  input  logic       chanB,
  input  logic       gateTb,
  input  logic       periodRef,
  input  logic       modePeriod,
  input  logic       chanSel,
  input  logic       armCmd,
  input  logic       clearCmd,
  output dpStrobe_t  strobe,
  output logic       done,
  output logic       gateOpen,
  output logic       armed
);

  measMode_e mode;
  logic countSel, gateSel;
  logic countPrev, gatePrev;
  logic countRise, gateRise;
  logic armFf, openFf, doneReg;
  logic busy;

  assign mode = measMode_e'(modePeriod);

  // source selection per measurement mode
  always_comb begin
    unique case (mode)
      MEAS_PERIOD: begin
        countSel = periodRef;
        gateSel  = chanA;
      end
      default: begin
        countSel = chanSel ? chanB : chanA;
        gateSel  = gateTb;
      end
    endcase
  end

  // one-sample history for rising-edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      countPrev <= 1'b0;
      gatePrev  <= 1'b0;
    end else begin
      countPrev <= countSel;
      gatePrev  <= gateSel;
    end
  end

  assign countRise = countSel & ~countPrev;
  assign gateRise  = gateSel & ~gatePrev;
  assign busy      = armFf | openFf;

  // arm / open flip-flop pair and registered completion flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armFf   <= 1'b0;
      openFf  <= 1'b0;
      doneReg <= 1'b0;
    end else if (clearCmd) begin
      armFf   <= 1'b0;
      openFf  <= 1'b0;
      doneReg <= 1'b0;
    end else if (openFf && gateRise) begin
      openFf  <= 1'b0;
      doneReg <= 1'b1;
    end else if (armFf && gateRise) begin
      openFf  <= 1'b1;
      armFf   <= 1'b0;
    end else if (armCmd && !busy) begin
      armFf   <= 1'b1;
      doneReg <= 1'b0;
    end
  end

  always_comb begin
    strobe.clr = clearCmd;
    strobe.inc = openFf & countRise & ~clearCmd;
  end

  assign done     = doneReg;
  assign gateOpen = openFf;
  assign armed    = armFf;

endmodule

// File: rtl/gcc_datapath.sv
module gcc_datapath
  import gcc_pkg::*;
#(
  parameter int unsigned NUM_DECADES = 4,
  parameter int unsigned LO_W        = 16,
  parameter int unsigned HI_W        = 8,
  localparam int unsigned BCD_W      = DIGIT_W * NUM_DECADES,
  localparam int unsigned EXT_W      = LO_W + HI_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpStrobe_t        strobe,
  output logic [BCD_W-1:0] bcdDigits,
  output logic [EXT_W-1:0] binExt
);

  logic [NUM_DECADES:0] decCarry;
  logic                 loCarry;
  logic                 hiCarry;

  assign decCarry[0] = strobe.inc;

  for (genvar d = 0; d < NUM_DECADES; d++) begin : g_decade
    gcc_decade u_decade (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (strobe.clr),
      .inc      (decCarry[d]),
      .digit    (bcdDigits[DIGIT_W*d +: DIGIT_W]),
      .carryOut (decCarry[d+1])
    );
  end

  gcc_binseg #(.W(LO_W)) u_binLo (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (strobe.clr),
    .inc      (decCarry[NUM_DECADES]),
    .value    (binExt[LO_W-1:0]),
    .carryOut (loCarry)
  );

  gcc_binseg #(.W(HI_W)) u_binHi (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (strobe.clr),
    .inc      (loCarry),
    .value    (binExt[EXT_W-1:LO_W]),
    .carryOut (hiCarry)
  );

  // the overall wrap of the count is silent by design
  logic unusedCarry;
  assign unusedCarry = hiCarry;

endmodule

// File: rtl/gate_counter_core.sv
module gate_counter_core
  import gcc_pkg::*;
#(
  parameter int unsigned NUM_DECADES = 4,
  parameter int unsigned LO_W        = 16,
  parameter int unsigned HI_W        = 8,
  localparam int unsigned BCD_W      = DIGIT_W * NUM_DECADES,
  localparam int unsigned EXT_W      = LO_W + HI_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chanA,
  input  logic             chanB,
  input  logic             gateTb,
  input  logic             periodRef,
  input  logic             modePeriod,
  input  logic             chanSel,
  input  logic             armCmd,
  input  logic             clearCmd,
  output logic             done,
  output logic [BCD_W-1:0] bcdDigits,
  output logic [EXT_W-1:0] binExt
);

  dpStrobe_t strobe;
  logic      gateOpen;
  logic      armed;

  gcc_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .chanA      (chanA),
    .chanB      (chanB),
    .gateTb     (gateTb),
    .periodRef  (periodRef),
    .modePeriod (modePeriod),
    .chanSel    (chanSel),
    .armCmd     (armCmd),
    .clearCmd   (clearCmd),
    .strobe     (strobe),
    .done       (done),
    .gateOpen   (gateOpen),
    .armed      (armed)
  );

  gcc_datapath #(
    .NUM_DECADES (NUM_DECADES),
    .LO_W        (LO_W),
    .HI_W        (HI_W)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .bcdDigits (bcdDigits),
    .binExt    (binExt)
  );

endmodule

// File: rtl/gcc_checker.sv
module gcc_checker #(
  parameter int unsigned BCD_W = 16,
  parameter int unsigned EXT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clearCmd,
  input logic             gateOpen,
  input logic             armed,
  input logic             done,
  input logic [BCD_W-1:0] bcdDigits,
  input logic [EXT_W-1:0] binExt
);

  localparam int unsigned NDIG = BCD_W / 4;

  logic digitsLegal;
  always_comb begin
    digitsLegal = 1'b1;
    for (int i = 0; i < NDIG; i++) begin
      if (bcdDigits[4*i +: 4] > 4'd9) digitsLegal = 1'b0;
    end
  end

  // R1
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clearCmd |=> (!done && bcdDigits == '0 && binExt == '0 && !gateOpen && !armed));

  // R4
  closed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(gateOpen) && !$past(clearCmd)) |-> ($stable(bcdDigits) && $stable(binExt)));

  // R4
  open_after_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gateOpen) |-> $past(armed));

  // R5
  close_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(gateOpen) && !$past(clearCmd)) |-> done);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!gateOpen && !armed));

  // R6
  arm_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gateOpen && !clearCmd) |=> !armed);

  // R7
  bcd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    digitsLegal);

endmodule

bind gate_counter_core gcc_checker #(
  .BCD_W (BCD_W),
  .EXT_W (EXT_W)
) u_gccChk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clearCmd  (clearCmd),
  .gateOpen  (gateOpen),
  .armed     (armed),
  .done      (done),
  .bcdDigits (bcdDigits),
  .binExt    (binExt)
);

// File: tb/test_gate_counter_core.sv
`timescale 1ns/1ps
module test_gate_counter_core;

  localparam int ND   = 2;
  localparam int LW   = 4;
  localparam int HW   = 2;
  localparam int BW   = 4 * ND;
  localparam int EW   = LW + HW;
  localparam int MODV = (10 ** ND) * (2 ** EW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chanA = 1'b0, chanB = 1'b0, gateTb = 1'b0, periodRef = 1'b0;
  logic modePeriod = 1'b0, chanSel = 1'b0, armCmd = 1'b0, clearCmd = 1'b0;
  logic done;
  logic [BW-1:0] bcdDigits;
  logic [EW-1:0] binExt;

  always #10 clk = ~clk;  // 50 MHz

  gate_counter_core #(.NUM_DECADES(ND), .LO_W(LW), .HI_W(HW)) i_gate_counter_core (
    .clk(clk), .rst_n(rst_n), .chanA(chanA), .chanB(chanB), .gateTb(gateTb),
    .periodRef(periodRef), .modePeriod(modePeriod), .chanSel(chanSel),
    .armCmd(armCmd), .clearCmd(clearCmd), .done(done),
    .bcdDigits(bcdDigits), .binExt(binExt)
  );

  int checks = 0;
  int fails  = 0;
  string curReq = "R1";
  bit compareOn = 1'b0;

  // ---------------- stimulus generators (0 hold, 1 random, 2 toggle)
  int aMode = 0, bMode = 0;
  int refDiv = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (aMode == 1) chanA = 1'($urandom);
      else if (aMode == 2) chanA = ~chanA;
      if (bMode == 1) chanB = 1'($urandom);
      else if (bMode == 2) chanB = ~chanB;
      refDiv = (refDiv + 1) % 3;
      if (refDiv == 0) periodRef = ~periodRef;
    end
  end

  // ---------------- behavioural reference model
  int  mCnt = 0;
  bit  mArmed = 0, mOpen = 0, mDone = 0, mPc = 0, mPg = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mCnt = 0; mArmed = 0; mOpen = 0; mDone = 0; mPc = 0; mPg = 0;
    end else begin
      bit cs, gs, cr, gr;
      cs = modePeriod ? periodRef : (chanSel ? chanB : chanA);
      gs = modePeriod ? chanA : gateTb;
      cr = cs && !mPc;
      gr = gs && !mPg;
      if (clearCmd) begin
        mCnt = 0; mArmed = 0; mOpen = 0; mDone = 0;
      end else begin
        if (mOpen && cr) mCnt = (mCnt + 1) % MODV;
        if (mOpen && gr) begin mOpen = 0; mDone = 1; end
        else if (mArmed && gr) begin mOpen = 1; mArmed = 0; end
        else if (armCmd && !mArmed && !mOpen) begin mArmed = 1; mDone = 0; end
      end
      mPc = cs;
      mPg = gs;
    end
  end

  function automatic int expBcd(int c);
    int r = 0;
    int v = c;
    for (int i = 0; i < ND; i++) begin
      r = r | ((v % 10) << (4 * i));
      v = v / 10;
    end
    return r;
  endfunction

  function automatic int expExt(int c);
    return c / (10 ** ND);
  endfunction

  task automatic chk(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (compareOn) begin
      chk({curReq, " done"}, int'(done), int'(mDone));
      chk({curReq, " bcd"}, int'(bcdDigits), expBcd(mCnt));
      chk({curReq, " ext"}, int'(binExt), expExt(mCnt));
    end
  end

  // wrap observation for R9
  bit sawMax = 0, sawWrap = 0;
  always @(negedge clk) begin
    if (compareOn) begin
      if (binExt == '1 && bcdDigits == 8'h99) sawMax = 1;
      else if (sawMax && binExt == '0 && bcdDigits == '0 && !clearCmd) sawWrap = 1;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic armPulse();
    @(negedge clk); armCmd = 1'b1;
    @(negedge clk); armCmd = 1'b0;
  endtask

  task automatic tbPulse();
    @(negedge clk); gateTb = 1'b1;
    @(negedge clk); gateTb = 1'b0;
  endtask

  task automatic aPulse();
    @(negedge clk); chanA = 1'b1;
    @(negedge clk); chanA = 1'b0;
  endtask

  task automatic clearPulse();
    @(negedge clk); clearCmd = 1'b1;
    @(negedge clk); clearCmd = 1'b0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    int snapB, snapE;
    cyc(4);
    // R1 reset state
    chk("R1 reset done", int'(done), 0);
    chk("R1 reset bcd", int'(bcdDigits), 0);
    chk("R1 reset ext", int'(binExt), 0);
    rst_n = 1'b1;
    compareOn = 1'b1;
    cyc(3);

    // R2 R4 R5: frequency mode, channel A random, channel B toggling
    curReq = "R2 R4 R5";
    aMode = 1; bMode = 2;
    cyc(5);
    armPulse();
    cyc(4);
    tbPulse();
    cyc(40);
    tbPulse();
    cyc(2);
    chk("R5 done after close", int'(done), 1);
    chk("R2 channel A count", int'(bcdDigits), expBcd(mCnt));

    // R10: gating rises with no arm change nothing
    curReq = "R10";
    snapB = int'(bcdDigits); snapE = int'(binExt);
    tbPulse(); cyc(10); tbPulse(); cyc(10);
    chk("R10 bcd unchanged", int'(bcdDigits), snapB);
    chk("R10 ext unchanged", int'(binExt), snapE);
    chk("R10 done kept", int'(done), 1);

    // R2 R6: channel B; arm clears done; arm during open ignored
    curReq = "R2 R6";
    chanSel = 1'b1;
    cyc(3);
    armPulse();
    cyc(1);
    chk("R6 arm clears done", int'(done), 0);
    tbPulse();
    cyc(10);
    armPulse();          // ignored while open
    cyc(20);
    tbPulse();
    cyc(2);
    chk("R6 done after close", int'(done), 1);
    snapB = int'(bcdDigits); snapE = int'(binExt);
    tbPulse(); cyc(20); tbPulse(); cyc(5);
    chk("R6 no reopen bcd", int'(bcdDigits), snapB);
    chk("R6 no reopen ext", int'(binExt), snapE);

    // R3: period mode, chanA gates, reference counted
    curReq = "R3";
    aMode = 0; chanA = 1'b0; chanSel = 1'b0;
    cyc(2);
    modePeriod = 1'b1;
    cyc(3);
    armPulse();
    cyc(3);
    aPulse();
    cyc(30);
    aPulse();
    cyc(2);
    chk("R3 done", int'(done), 1);
    chk("R3 count", int'(bcdDigits), expBcd(mCnt));

    // R1: clear in the middle of a measurement
    curReq = "R1";
    modePeriod = 1'b0; aMode = 2;
    cyc(3);
    armPulse();
    tbPulse();
    cyc(15);
    clearPulse();
    chk("R1 clear bcd", int'(bcdDigits), 0);
    chk("R1 clear done", int'(done), 0);
    tbPulse(); cyc(20); tbPulse(); cyc(5);
    chk("R1 closed after clear", int'(bcdDigits), 0);

    // R7 R8 R9: long gate driving the full wrap
    curReq = "R7 R8 R9";
    armPulse();
    tbPulse();
    cyc(13300);
    tbPulse();
    cyc(3);
    chk("R9 reached max", int'(sawMax), 1);
    chk("R9 wrapped", int'(sawWrap), 1);
    chk("R7 R8 final", int'(bcdDigits), expBcd(mCnt));
    chk("R5 final done", int'(done), 1);

    compareOn = 1'b0;
    summary();
  end

endmodule